// File: doc/BRIEF.md
# Stack Node Command Decoder

This block holds the command-handling state of one node in a daisy-chained stack of monitoring devices. Each command reaches it already framed, as a single-cycle strobe. The strobe carries an opcode, a 4-bit target address and an Identify payload. The block checks the target against the node's own address and the broadcast code. It then decides whether the command applies to this node and updates three pieces of state: the node's stack address, the stack size and the balance-enable bit. It also raises a one-cycle request whenever the framing logic must send a reply.

Every accepted command takes effect on the clock edge that samples the strobe, so the outputs show the result one cycle later. Reset is a special case. It works only when the command names this node directly. It is refused when broadcast, and it is never answered. After a Reset, the node has no address until an Identify loads a new one. The balance commands work both addressed and broadcast. Driving the enable pin low clears the node in the same way as an accepted Reset.

Top module: `stack_node_cmd`

## Requirements
- R1: After `rst_n` is released, `node_addr`, `stack_size`, `bal_en` and `rsp_req` are all zero.
- R2: A Reset command (opcode 1) whose target equals the node's non-zero address clears `node_addr`, `stack_size` and `bal_en` on the next cycle.
- R3: A Reset command sent to the broadcast code 4'hF changes no state.
- R4: A Reset command never raises `rsp_req`, whether it is accepted or not.
- R5: Balance Enable (opcode 2) sets `bal_en` when its target is the node's own non-zero address or 4'hF.
- R6: Balance Inhibit (opcode 3) clears `bal_en` when its target is the node's own non-zero address or 4'hF.
- R7: A command is ignored, with no state change and no reply, when its target is neither 4'hF nor the node's address. A target of 0 never matches, even when the node's address is 0.
- R8: Identify (opcode 0) loads `cmd_new_addr` into `node_addr` and `cmd_new_size` into `stack_size`. It is accepted when the node is unassigned (address 0) and the target is 4'hF, or when the target is the node's own non-zero address.
- R9: An Identify whose payload address is 0 or 4'hF is refused and changes nothing.
- R10: `rsp_req` pulses for one cycle after an accepted Identify or after an accepted balance command addressed to the node's own address. It stays low after a broadcast balance command.
- R11: While `en` is low, all state is held at zero and commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable pin; low acts as hard reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 2 | 0 Identify, 1 Reset, 2 Balance Enable, 3 Balance Inhibit |
| cmd_tgt | input | 4 | Target address; 4'hF is broadcast |
| cmd_new_addr | input | 4 | Identify payload: new node address |
| cmd_new_size | input | 4 | Identify payload: new stack size |
| node_addr | output | 4 | Stored stack address; 0 means unassigned |
| stack_size | output | 4 | Stored stack size |
| bal_en | output | 1 | Balance-enable bit |
| rsp_req | output | 1 | One-cycle request for a reply frame |

## Verification
The bench sends a Reset to the broadcast code while the node holds an address and has balancing enabled. A design that let the broadcast through would drop the node's address and stop its balancing. It also sends a target of 0 to a node that is already cleared to 0. A decoder that compared addresses without checking for "unassigned" would wrongly treat that command as its own. Identify is tried with payload addresses 0 and 4'hF, and the bench checks that the node does not take on a broken address. Broadcast balance commands are checked for a missing reply. Addressed Reset commands are checked for the absence of any reply, because a spurious answer would collide on the chain.

// File: rtl/stack_node_cmd.sv
module stack_node_cmd #(
  parameter int AW = 4,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_tgt,
  input  logic [AW-1:0] cmd_new_addr,
  input  logic [SW-1:0] cmd_new_size,
  output logic [AW-1:0] node_addr,
  output logic [SW-1:0] stack_size,
  output logic          bal_en,
  output logic          rsp_req
);
  localparam logic [AW-1:0] BCAST = '1;
  localparam logic [AW-1:0] NONE  = '0;
  localparam logic [1:0] OP_IDENT = 2'd0;
  localparam logic [1:0] OP_RESET = 2'd1;
  localparam logic [1:0] OP_BON   = 2'd2;
  localparam logic [1:0] OP_BOFF  = 2'd3;

  logic go, is_bc, is_own, id_ok, rst_ok, bon_ok, boff_ok;

  assign go      = en && cmd_valid;
  assign is_bc   = cmd_tgt == BCAST;
  assign is_own  = (node_addr != NONE) && (cmd_tgt == node_addr);
  assign id_ok   = go && cmd_op == OP_IDENT && ((is_bc && node_addr == NONE) || is_own)
                   && cmd_new_addr != NONE && cmd_new_addr != BCAST;
  assign rst_ok  = go && cmd_op == OP_RESET && is_own;
  assign bon_ok  = go && cmd_op == OP_BON  && (is_own || is_bc);
  assign boff_ok = go && cmd_op == OP_BOFF && (is_own || is_bc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_addr  <= NONE;
      stack_size <= '0;
      bal_en     <= 1'b0;
      rsp_req    <= 1'b0;
    end else if (!en || rst_ok) begin
      node_addr  <= NONE;
      stack_size <= '0;
      bal_en     <= 1'b0;
      rsp_req    <= 1'b0;
    end else begin
      if (id_ok) begin
        node_addr  <= cmd_new_addr;
        stack_size <= cmd_new_size;
      end
      if (bon_ok)  bal_en <= 1'b1;
      if (boff_ok) bal_en <= 1'b0;
      rsp_req <= id_ok || ((bon_ok || boff_ok) && is_own);
    end
  end

  AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> node_addr == NONE && stack_size == '0 && !bal_en && !rsp_req); // R11
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_op == OP_RESET && node_addr != NONE && cmd_tgt == node_addr
    |=> node_addr == NONE && stack_size == '0 && !bal_en); // R2
  AST_BC_RESET_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_op == OP_RESET && cmd_tgt == BCAST
    |=> $stable(node_addr) && $stable(stack_size) && $stable(bal_en)); // R3
  AST_RESET_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_RESET |=> !rsp_req); // R4
  AST_BEN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_op == OP_BON && (cmd_tgt == BCAST || (node_addr != NONE && cmd_tgt == node_addr))
    |=> bal_en); // R5
  AST_BEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_op == OP_BOFF && (cmd_tgt == BCAST || (node_addr != NONE && cmd_tgt == node_addr))
    |=> !bal_en); // R6
  AST_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_tgt != BCAST && cmd_tgt != node_addr
    |=> $stable(node_addr) && $stable(stack_size) && $stable(bal_en) && !rsp_req); // R7
  AST_ID_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_op == OP_IDENT && (cmd_new_addr == NONE || cmd_new_addr == BCAST)
    |=> $stable(node_addr) && $stable(stack_size) && !rsp_req); // R9
  AST_BC_BAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    en && cmd_valid && cmd_op[1] && cmd_tgt == BCAST |=> !rsp_req); // R10
endmodule

// File: tb/stack_node_cmd_test.sv
module stack_node_cmd_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [3:0] cmd_tgt = '0, cmd_new_addr = '0, cmd_new_size = '0;
  logic [3:0] node_addr, stack_size;
  logic bal_en, rsp_req;
  int total = 0, bad = 0;
  logic [3:0] m_addr = '0, m_size = '0;
  logic m_ben = 1'b0, m_rsp = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stack_node_cmd uut (.clk(clk), .rst_n(rst_n), .en(en), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_tgt(cmd_tgt), .cmd_new_addr(cmd_new_addr), .cmd_new_size(cmd_new_size),
    .node_addr(node_addr), .stack_size(stack_size), .bal_en(bal_en), .rsp_req(rsp_req));

  function automatic string model(input logic v, input logic [1:0] op, input logic [3:0] t,
                                  input logic [3:0] a, input logic [3:0] s, input logic e);
    logic bc, own;
    string tag;
    bc = t == 4'hF;
    own = m_addr != 0 && t == m_addr;
    m_rsp = 1'b0;
    tag = "R7";
    if (!e) begin
      m_addr = 0; m_size = 0; m_ben = 0; tag = "R11";
    end else if (v) begin
      case (op)
        2'd0: begin
          tag = (a == 0 || a == 4'hF) ? "R9" : "R8";
          if (((bc && m_addr == 0) || own) && a != 0 && a != 4'hF) begin
            m_addr = a; m_size = s; m_rsp = 1'b1;
          end
        end
        2'd1: begin
          tag = bc ? "R3" : "R2";
          if (own) begin m_addr = 0; m_size = 0; m_ben = 0; end
        end
        2'd2: begin tag = bc ? "R10" : "R5"; if (own || bc) begin m_ben = 1; m_rsp = own; end end
        default: begin tag = bc ? "R10" : "R6"; if (own || bc) begin m_ben = 0; m_rsp = own; end end
      endcase
      if (!own && !bc && op != 2'd0) tag = "R7";
    end
    return tag;
  endfunction

  task automatic compare(input string tag);
    total++;
    if (node_addr !== m_addr || stack_size !== m_size || bal_en !== m_ben || rsp_req !== m_rsp) begin
      bad++;
      $display("FAIL %s: addr=%h size=%h ben=%b rsp=%b expected addr=%h size=%h ben=%b rsp=%b",
               tag, node_addr, stack_size, bal_en, rsp_req, m_addr, m_size, m_ben, m_rsp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] op, input logic [3:0] t,
                      input logic [3:0] a, input logic [3:0] s, input logic e);
    string tag;
    cmd_valid = v; cmd_op = op; cmd_tgt = t; cmd_new_addr = a; cmd_new_size = s; en = e;
    tag = model(v, op, t, a, s, e);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");
    step(1, 2'd2, 4'h0, 4'h0, 4'h0, 1);   // R7 target 0 on unassigned node
    step(1, 2'd0, 4'hF, 4'h5, 4'h9, 1);   // R8 identify by broadcast
    step(1, 2'd0, 4'h3, 4'h7, 4'h2, 1);   // R7 foreign identify
    step(1, 2'd2, 4'hF, 4'h0, 4'h0, 1);   // R5 R10 broadcast enable, no reply
    step(1, 2'd1, 4'hF, 4'h0, 4'h0, 1);   // R3 broadcast reset refused
    step(1, 2'd0, 4'h5, 4'h0, 4'h1, 1);   // R9 payload 0
    step(1, 2'd0, 4'h5, 4'hF, 4'h1, 1);   // R9 payload broadcast code
    step(1, 2'd3, 4'h5, 4'h0, 4'h0, 1);   // R6 R10 addressed inhibit replies
    step(1, 2'd2, 4'h5, 4'h0, 4'h0, 1);   // R5
    step(1, 2'd1, 4'h5, 4'h0, 4'h0, 1);   // R2 R4 own reset, silent
    step(1, 2'd2, 4'h5, 4'h0, 4'h0, 1);   // R7 old address no longer matches
    step(0, 2'd0, 4'h0, 4'h0, 4'h0, 1);
    step(1, 2'd0, 4'hF, 4'h2, 4'h6, 1);   // R8
    step(1, 2'd2, 4'h2, 4'h0, 4'h0, 1);   // R5
    step(1, 2'd0, 4'hF, 4'h4, 4'h4, 0);   // R11 enable low
    step(1, 2'd0, 4'hF, 4'h4, 4'h4, 1);   // R8 after hard reset
    for (int i = 0; i < 600; i++) begin
      logic [3:0] t, a;
      logic [1:0] op;
      int k;
      k = $urandom_range(0, 3);
      t = (k == 0) ? m_addr : (k == 1) ? 4'hF : (k == 2) ? 4'h0 : 4'($urandom_range(0, 15));
      a = ($urandom_range(0, 9) == 0) ? 4'hF : 4'($urandom_range(0, 14));
      op = 2'($urandom_range(0, 3));
      step($urandom_range(0, 9) != 0, op, t, a, 4'($urandom_range(0, 15)),
           $urandom_range(0, 29) != 0);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule